// File: doc/BRIEF.md
# USB Low/Full-Speed Packet Receiver

A passive receive path for low- and full-speed USB traffic. The block takes the D+ and D- line levels, sampled four times per bit by a clock that is already synchronous to it. It never drives the bus, so it can sit beside a live link as a monitor. A phase counter is restarted on every J/K transition, and one sample near the middle of each bit is taken from it. That sample is turned from NRZI into a data bit, and the zero a sender inserts after six consecutive ones is removed. The remaining stream is framed on the sync pattern.

After the sync, bits are packed least-significant first into bytes. The block reports the start of each packet, each completed byte, the end of the packet and three kinds of error, each as a one-cycle strobe. End-of-packet is a single-ended zero (both lines low) held long enough to pass a glitch filter. Three conditions abandon a packet: a missing stuffed zero, both lines high, or a sync that is not valid. After any of them the receiver waits for the next end-of-packet before it looks for a new packet. CRC checks, PID meaning and transaction decoding belong to later stages.

Top module: `usb_pkt_rx`

## Requirements
- R1: A bit period that holds a J/K transition decodes as 0, and one without a transition decodes as 1. Line state J is D+=1/D-=0, K is D+=0/D-=1, SE0 is 00 and SE1 is 11, with full-speed polarity by default.
- R2: Inside a packet, a 0 that follows six consecutive 1 bits (the trailing 1 of the sync counts) is discarded. It never appears in a byte and never counts toward a partial byte.
- R3: While idle, the first decoded 0 starts a sync hunt. Seven or more 0 bits followed by a 1 give exactly one rx_sop pulse. A 1 after fewer zeros abandons the attempt with no rx_sop and no bytes.
- R4: After rx_sop, every eight data bits give one rx_valid pulse, and rx_byte holds the first received bit in bit 0.
- R5: An SE0 that lasts at least two samples inside a packet gives one rx_eop pulse. A single-sample SE0 has no effect on the decoded bytes.
- R6: A seventh consecutive 1 bit inside a packet gives a one-cycle rx_err_stuff pulse. After it the packet gives no further bytes and no rx_eop.
- R7: When end-of-packet arrives with a partly assembled byte (1 to 7 bits), rx_err_frame pulses in the same cycle as rx_eop and the partial byte is dropped. When no partial byte is pending, rx_err_frame stays low.
- R8: An SE1 sample inside a packet gives a one-cycle rx_err_se1 pulse. After it the packet gives no further bytes and no rx_eop.
- R9: Right after reset, every strobe output is low.
- R10: Once an end-of-packet or an abandoned packet has been followed by SE0, the receiver returns to edge scanning, and the next packet is received in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, four samples per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp | input | 1 | Synchronous D+ line sample |
| dm | input | 1 | Synchronous D- line sample |
| rx_byte | output | 8 | Last assembled data byte |
| rx_valid | output | 1 | One-cycle strobe, rx_byte is new |
| rx_sop | output | 1 | One-cycle strobe, valid sync seen |
| rx_eop | output | 1 | One-cycle strobe, end-of-packet |
| rx_err_stuff | output | 1 | One-cycle strobe, missing stuffed zero |
| rx_err_frame | output | 1 | One-cycle strobe with rx_eop, partial byte dropped |
| rx_err_se1 | output | 1 | One-cycle strobe, both lines high in a packet |

## Verification
The bench builds the block with its default parameters: four samples per bit, a two-sample SE0 filter, a six-ones stuffing run, a seven-zero sync and full-speed polarity. With four samples per bit, the bench can put an SE0 glitch on the last sample of a bit, away from the sampling point, and can place an SE1 on exact bit boundaries. The two-sample filter lets the bench separate a one-sample SE0 glitch from a real end-of-packet. The six-ones run brings stuffed zeros within reach at the end of a packet and across the sync/data border, while random packets weighted toward 0xFF bytes cover longer stretches without transitions.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'b00,
      FR_HUNT  = 2'b01,
      FR_DATA  = 2'b10,
      FR_ABORT = 2'b11
   } fr_state_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/usbrx_line_decode.sv
module usbrx_line_decode
   import usbrx_pkg::*;
#(
   parameter int unsigned LOW_SPEED = 0,
   parameter int unsigned SE0_MIN   = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  dp,
   input  logic  dm,
   output line_t line,
   output logic  se0_det
);

   localparam int unsigned RW = $clog2(SE0_MIN + 1);

   logic [RW-1:0] se0_run;

   generate
      if (LOW_SPEED != 0) begin : g_low_pol
         always_comb begin
            unique case ({dp, dm})
               2'b00:   line = LN_SE0;
               2'b01:   line = LN_J;
               2'b10:   line = LN_K;
               default: line = LN_SE1;
            endcase
         end
      end else begin : g_full_pol
         always_comb begin
            unique case ({dp, dm})
               2'b00:   line = LN_SE0;
               2'b10:   line = LN_J;
               2'b01:   line = LN_K;
               default: line = LN_SE1;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         se0_run <= '0;
      end else if (line == LN_SE0) begin
         if (se0_run != RW'(SE0_MIN)) se0_run <= se0_run + 1'b1;
      end else begin
         se0_run <= '0;
      end
   end

   assign se0_det = (line == LN_SE0) && (se0_run == RW'(SE0_MIN - 1));

endmodule

// File: rtl/usbrx_bit_recover.sv
module usbrx_bit_recover
   import usbrx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  line_t line,
   input  logic  se0_det,
   output logic  bit_stb,
   output logic  bit_val
);

   localparam int unsigned PW     = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam int unsigned CENTER = OVERSAMPLE / 2;

   logic          is_data;
   logic          lvl;
   logic          last_lvl;
   logic          ref_lvl;
   logic          edge_now;
   logic [PW-1:0] phase;
   logic [PW-1:0] ph_cur;
   logic [PW-1:0] ph_next;

   assign is_data  = (line == LN_J) || (line == LN_K);
   assign lvl      = (line == LN_K);
   assign edge_now = is_data && (lvl != last_lvl);
   assign ph_cur   = edge_now ? '0 : phase;
   assign ph_next  = (ph_cur == PW'(OVERSAMPLE - 1)) ? '0 : ph_cur + 1'b1;
   assign bit_stb  = is_data && (ph_cur == PW'(CENTER));
   assign bit_val  = (lvl == ref_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         last_lvl <= 1'b0;
         ref_lvl  <= 1'b0;
      end else begin
         phase <= ph_next;
         if (is_data) begin
            last_lvl <= lvl;
         end else if (se0_det) begin
            last_lvl <= 1'b0;
            ref_lvl  <= 1'b0;
         end
         if (bit_stb) ref_lvl <= lvl;
      end
   end

endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff #(
   parameter int unsigned STUFF_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic bit_stb,
   input  logic bit_val,
   output logic out_stb,
   output logic out_val,
   output logic stuff_err
);

   localparam int unsigned CW = $clog2(STUFF_RUN + 2);

   logic [CW-1:0] ones;
   logic          at_limit;
   logic          drop;

   assign at_limit  = (ones == CW'(STUFF_RUN));
   assign drop      = active && bit_stb && !bit_val && at_limit;
   assign stuff_err = active && bit_stb && bit_val && at_limit;
   assign out_stb   = bit_stb && !drop;
   assign out_val   = bit_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones <= '0;
      end else if (bit_stb) begin
         if (!bit_val)                       ones <= '0;
         else if (ones != CW'(STUFF_RUN + 1)) ones <= ones + 1'b1;
      end
   end

endmodule

// File: rtl/usbrx_framer.sv
module usbrx_framer
   import usbrx_pkg::*;
#(
   parameter int unsigned SYNC_ZEROS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_t             line,
   input  logic              se0_det,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              stuff_err,
   output logic              active,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              rx_sop,
   output logic              rx_eop,
   output logic              rx_err_stuff,
   output logic              rx_err_frame,
   output logic              rx_err_se1
);

   localparam int unsigned ZW = $clog2(SYNC_ZEROS + 1);
   localparam int unsigned BW = $clog2(BYTE_W);

   fr_state_t         state;
   logic [ZW-1:0]     zrun;
   logic [BYTE_W-1:0] shreg;
   logic [BW-1:0]     bcnt;
   logic [BYTE_W-1:0] shnext;

   assign active = (state == FR_DATA);
   assign shnext = {bit_val, shreg[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= FR_IDLE;
         zrun         <= '0;
         shreg        <= '0;
         bcnt         <= '0;
         rx_byte      <= '0;
         rx_valid     <= 1'b0;
         rx_sop       <= 1'b0;
         rx_eop       <= 1'b0;
         rx_err_stuff <= 1'b0;
         rx_err_frame <= 1'b0;
         rx_err_se1   <= 1'b0;
      end else begin
         rx_valid     <= 1'b0;
         rx_sop       <= 1'b0;
         rx_eop       <= 1'b0;
         rx_err_stuff <= 1'b0;
         rx_err_frame <= 1'b0;
         rx_err_se1   <= 1'b0;
         unique case (state)
            FR_IDLE: begin
               if (bit_stb && !bit_val) begin
                  state <= FR_HUNT;
                  zrun  <= ZW'(1);
               end
            end
            FR_HUNT: begin
               if (se0_det) begin
                  state <= FR_IDLE;
               end else if (line == LN_SE1) begin
                  state <= FR_ABORT;
               end else if (bit_stb) begin
                  if (!bit_val) begin
                     if (zrun != ZW'(SYNC_ZEROS)) zrun <= zrun + 1'b1;
                  end else if (zrun == ZW'(SYNC_ZEROS)) begin
                     state  <= FR_DATA;
                     rx_sop <= 1'b1;
                     bcnt   <= '0;
                  end else begin
                     state <= FR_ABORT;
                  end
               end
            end
            FR_DATA: begin
               if (se0_det) begin
                  state        <= FR_IDLE;
                  rx_eop       <= 1'b1;
                  rx_err_frame <= (bcnt != '0);
               end else if (line == LN_SE1) begin
                  state      <= FR_ABORT;
                  rx_err_se1 <= 1'b1;
               end else if (stuff_err) begin
                  state        <= FR_ABORT;
                  rx_err_stuff <= 1'b1;
               end else if (bit_stb) begin
                  shreg <= shnext;
                  bcnt  <= bcnt + 1'b1;
                  if (bcnt == BW'(BYTE_W - 1)) begin
                     rx_byte  <= shnext;
                     rx_valid <= 1'b1;
                  end
               end
            end
            default: begin
               if (se0_det) state <= FR_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/usb_pkt_rx.sv
module usb_pkt_rx
   import usbrx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 4,
   parameter int unsigned SE0_MIN    = 2,
   parameter int unsigned STUFF_RUN  = 6,
   parameter int unsigned SYNC_ZEROS = 7,
   parameter int unsigned LOW_SPEED  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dp,
   input  logic       dm,
   output logic [7:0] rx_byte,
   output logic       rx_valid,
   output logic       rx_sop,
   output logic       rx_eop,
   output logic       rx_err_stuff,
   output logic       rx_err_frame,
   output logic       rx_err_se1
);

   generate
      if (OVERSAMPLE < 3) begin : g_bad_os
         $error("OVERSAMPLE must be at least 3");
      end
      if (SE0_MIN < 2 || SE0_MIN >= OVERSAMPLE * 2) begin : g_bad_se0
         $error("SE0_MIN must lie between 2 and two bit periods");
      end
      if (STUFF_RUN < 1) begin : g_bad_stuff
         $error("STUFF_RUN must be at least 1");
      end
      if (SYNC_ZEROS < 1) begin : g_bad_sync
         $error("SYNC_ZEROS must be at least 1");
      end
   endgenerate

   line_t line;
   logic  se0_det;
   logic  raw_stb;
   logic  raw_val;
   logic  dat_stb;
   logic  dat_val;
   logic  stuff_err;
   logic  active;

   usbrx_line_decode #(
      .LOW_SPEED (LOW_SPEED),
      .SE0_MIN   (SE0_MIN)
   ) line_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .dp      (dp),
      .dm      (dm),
      .line    (line),
      .se0_det (se0_det)
   );

   usbrx_bit_recover #(
      .OVERSAMPLE (OVERSAMPLE)
   ) rec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .line    (line),
      .se0_det (se0_det),
      .bit_stb (raw_stb),
      .bit_val (raw_val)
   );

   usbrx_unstuff #(
      .STUFF_RUN (STUFF_RUN)
   ) uns_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .bit_stb   (raw_stb),
      .bit_val   (raw_val),
      .out_stb   (dat_stb),
      .out_val   (dat_val),
      .stuff_err (stuff_err)
   );

   usbrx_framer #(
      .SYNC_ZEROS (SYNC_ZEROS)
   ) frm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .line         (line),
      .se0_det      (se0_det),
      .bit_stb      (dat_stb),
      .bit_val      (dat_val),
      .stuff_err    (stuff_err),
      .active       (active),
      .rx_byte      (rx_byte),
      .rx_valid     (rx_valid),
      .rx_sop       (rx_sop),
      .rx_eop       (rx_eop),
      .rx_err_stuff (rx_err_stuff),
      .rx_err_frame (rx_err_frame),
      .rx_err_se1   (rx_err_se1)
   );

endmodule

// File: rtl/usb_pkt_rx_chk.sv
module usb_pkt_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic dp,
   input logic dm,
   input logic rx_valid,
   input logic rx_sop,
   input logic rx_eop,
   input logic rx_err_stuff,
   input logic rx_err_frame,
   input logic rx_err_se1
);

   logic in_pkt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    in_pkt <= 1'b0;
      else if (rx_sop)                               in_pkt <= 1'b1;
      else if (rx_eop || rx_err_stuff || rx_err_se1) in_pkt <= 1'b0;
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_sop, rx_valid, rx_eop})); // R3

   AST_SOP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sop |-> !in_pkt); // R3

   AST_VALID_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> in_pkt); // R4

   AST_EOP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eop |-> in_pkt); // R5

   AST_EOP_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eop |-> (!$past(dp) && !$past(dm) && !$past(dp, 2) && !$past(dm, 2))); // R5

   AST_STUFF_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_stuff |-> (in_pkt && !rx_valid && !rx_eop)); // R6

   AST_FRAME_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_frame |-> rx_eop); // R7

   AST_SE1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err_se1 |-> (in_pkt && $past(dp) && $past(dm))); // R8

endmodule

bind usb_pkt_rx usb_pkt_rx_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .dp           (dp),
   .dm           (dm),
   .rx_valid     (rx_valid),
   .rx_sop       (rx_sop),
   .rx_eop       (rx_eop),
   .rx_err_stuff (rx_err_stuff),
   .rx_err_frame (rx_err_frame),
   .rx_err_se1   (rx_err_se1)
);

// File: tb/usb_pkt_rx_tb_top.sv
`timescale 1ns/1ps
module usb_pkt_rx_tb_top;

   localparam logic [1:0] LJ   = 2'b10;
   localparam logic [1:0] LK   = 2'b01;
   localparam logic [1:0] LSE0 = 2'b00;
   localparam logic [1:0] LSE1 = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dp = 1'b1;
   logic       dm = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_valid, rx_sop, rx_eop, rx_err_stuff, rx_err_frame, rx_err_se1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   usb_pkt_rx dut_i (
      .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
      .rx_err_stuff(rx_err_stuff), .rx_err_frame(rx_err_frame), .rx_err_se1(rx_err_se1)
   );

   // capture of output events
   logic [7:0] cap [0:63];
   int ncap = 0, nsop = 0, neop = 0, nstuff = 0, nframe = 0, nse1 = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            if (ncap < 64) cap[ncap] = rx_byte;
            ncap++;
         end
         if (rx_sop)       nsop++;
         if (rx_eop)       neop++;
         if (rx_err_stuff) nstuff++;
         if (rx_err_frame) nframe++;
         if (rx_err_se1)   nse1++;
      end
   end

   task automatic clear_caps();
      ncap = 0; nsop = 0; neop = 0; nstuff = 0; nframe = 0; nse1 = 0;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // transmitter state
   logic [7:0] pkt [0:31];
   logic       raw [0:1023];
   int         raw_n;
   logic       tx_lvl;
   int         tx_ones, tx_enc, tx_glitch, tx_se1;

   task automatic drv(input logic [1:0] v);
      @(negedge clk);
      dp = v[1];
      dm = v[0];
   endtask

   task automatic tx_bit(input logic b);
      if (!b) tx_lvl = ~tx_lvl;
      tx_ones = b ? tx_ones + 1 : 0;
      for (int s = 0; s < 4; s++) begin
         if (tx_enc == tx_se1)                 drv(LSE1);
         else if (tx_enc == tx_glitch && s == 3) drv(LSE0);
         else                                  drv(tx_lvl ? LK : LJ);
      end
      tx_enc++;
   endtask

   task automatic send(input logic [7:0] syncv, input int nb, input int tail_n,
                       input logic [7:0] tailv, input bit stuff_en,
                       input int glitch_bit, input int se1_bit);
      raw_n = 0;
      for (int i = 0; i < 8; i++) begin raw[raw_n] = syncv[i]; raw_n++; end
      for (int b = 0; b < nb; b++)
         for (int i = 0; i < 8; i++) begin raw[raw_n] = pkt[b][i]; raw_n++; end
      for (int i = 0; i < tail_n; i++) begin raw[raw_n] = tailv[i]; raw_n++; end
      tx_lvl = 1'b0; tx_ones = 0; tx_enc = 0;
      tx_glitch = glitch_bit; tx_se1 = se1_bit;
      for (int k = 0; k < raw_n; k++) begin
         tx_bit(raw[k]);
         if (stuff_en && tx_ones == 6) tx_bit(1'b0);
      end
      for (int i = 0; i < 8; i++) drv(LSE0);
      for (int i = 0; i < 12; i++) drv(LJ);
   endtask

   function automatic bit exp_frame_err(input int tail_n);
      return (tail_n % 8) != 0;
   endfunction

   task automatic check_bytes(input int nb, input string req);
      chk(ncap == nb, req, ncap, nb);
      for (int b = 0; b < nb && b < ncap; b++)
         chk(cap[b] == pkt[b], req, cap[b], pkt[b]);
   endtask

   task automatic check_clean(input int nb, input string req);
      check_bytes(nb, req);
      chk(nsop == 1, "R3 sop count", nsop, 1);
      chk(neop == 1, "R5 eop count", neop, 1);
      chk(nstuff + nframe + nse1 == 0, "R6 R7 R8 no error", nstuff + nframe + nse1, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk({rx_valid, rx_sop, rx_eop, rx_err_stuff, rx_err_frame, rx_err_se1} == 6'b0,
          "R9 strobes after reset",
          {rx_valid, rx_sop, rx_eop, rx_err_stuff, rx_err_frame, rx_err_se1}, 0);
      repeat (8) drv(LJ);

      // R1 R4: directed mixed pattern
      clear_caps();
      pkt[0] = 8'hA5; pkt[1] = 8'h00; pkt[2] = 8'h69;
      send(8'h80, 3, 0, 8'h00, 1, -1, -1);
      check_clean(3, "R1 R4 directed bytes");

      // R2: long runs of ones with stuffed zeros
      clear_caps();
      pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h7F;
      send(8'h80, 4, 0, 8'h00, 1, -1, -1);
      check_clean(4, "R2 stuffed ones");

      // R2 R7: stuffed zero right before EOP gives no frame error
      clear_caps();
      pkt[0] = 8'hFC;
      send(8'h80, 1, 0, 8'h00, 1, -1, -1);
      check_clean(1, "R2 trailing stuff");
      chk(nframe == 0, "R7 no frame err on trailing stuff", nframe, 0);

      // R5: single-sample SE0 glitch on bit 13 is ignored
      clear_caps();
      pkt[0] = 8'h3C; pkt[1] = 8'hC3;
      send(8'h80, 2, 0, 8'h00, 1, 13, -1);
      check_clean(2, "R5 glitch ignored");

      // R7: partial byte at EOP
      clear_caps();
      pkt[0] = 8'h5A;
      send(8'h80, 1, 3, 8'h05, 1, -1, -1);
      check_bytes(1, "R7 partial dropped");
      chk(neop == 1, "R7 eop with partial", neop, 1);
      chk(nframe == int'(exp_frame_err(3)), "R7 frame err", nframe, 1);

      // R6: seven ones without stuffing
      clear_caps();
      pkt[0] = 8'h3C; pkt[1] = 8'hFF; pkt[2] = 8'h12;
      send(8'h80, 3, 0, 8'h00, 0, -1, -1);
      check_bytes(1, "R6 bytes before stuff error");
      chk(nstuff == 1, "R6 stuff err", nstuff, 1);
      chk(neop == 0, "R6 no eop after abort", neop, 0);

      // R8: SE1 at encoded bit 24 (start of third byte)
      clear_caps();
      pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
      send(8'h80, 3, 0, 8'h00, 1, -1, 24);
      check_bytes(2, "R8 bytes before se1");
      chk(nse1 == 1, "R8 se1 err", nse1, 1);
      chk(neop == 0, "R8 no eop after abort", neop, 0);

      // R3: short sync (three zeros then one) is rejected
      clear_caps();
      pkt[0] = 8'h44; pkt[1] = 8'h99;
      send(8'h88, 2, 0, 8'h00, 1, -1, -1);
      chk(nsop == 0, "R3 bad sync no sop", nsop, 0);
      chk(ncap == 0, "R3 bad sync no bytes", ncap, 0);
      chk(neop == 0, "R3 bad sync no eop", neop, 0);

      // R10: recovery after abort
      clear_caps();
      pkt[0] = 8'hE7;
      send(8'h80, 1, 0, 8'h00, 1, -1, -1);
      check_clean(1, "R10 recovery");

      // R1 R2 R4 R10: random back-to-back packets
      for (int p = 0; p < 24; p++) begin
         int len;
         len = 1 + int'($urandom % 12);
         for (int b = 0; b < len; b++)
            pkt[b] = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 256);
         clear_caps();
         send(8'h80, len, 0, 8'h00, 1, -1, -1);
         check_clean(len, "R1 R2 R4 R10 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule